// File: doc/BRIEF.md
# State-Priority Replacement Victim Selector

This block picks which of a set of block frames gives up its slot when a new block has to be brought into a node's local store. Each frame reports a two-bit coherence state. The selector prefers frames that hold nothing useful. Next come frames holding a plain shared copy, then frames that own a block others only read. Frames that are held writable are taken last. Among writable frames, the one whose last use lies furthest in the past is chosen.

Recency is tracked for every frame, whatever its state, through per-frame touch strobes. A frame that turns writable therefore keeps its full history. A request is answered one cycle later with a valid pulse and the victim index. A separate flag tells the caller that the victim holds the owning copy, so the block must be moved elsewhere or its remote copies invalidated before the frame is reused. Where the block goes is decided outside this block.

Top module: `victim_sel`

## Requirements
- R1: `victimVld` is high for exactly one cycle, in the cycle after each cycle in which `selReq` is high. It is low in every other cycle, including during and right after reset.
- R2: Frame i reports its state on `frameState[2i+1:2i]`, encoded as 0 = empty, 1 = shared read copy, 2 = owned read copy, 3 = writable.
- R3: If any frame is empty at the request, the victim is the empty frame with the lowest index.
- R4: If no frame is empty and at least one holds a shared read copy, the victim is the lowest-indexed such frame.
- R5: If no frame is empty or shared, and at least one holds an owned read copy, the victim is the lowest-indexed such frame.
- R6: If every frame is writable, the victim is the least recently used frame.
- R7: After reset the recency order is by index, with frame N-1 least recent and frame 0 most recent. A touch makes that frame the most recent and keeps the relative order of all other frames.
- R8: When several `touchVld` bits are high in one cycle, only the lowest-indexed one is recorded.
- R9: `victimNeedsPlace` is high only together with `victimVld`, and exactly when the chosen frame was owned-read or writable at the request.
- R10: The choice uses the states and recency order as they stand in the request cycle. A touch in that same cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameState | input | 2*NUM_FRAMES | Per-frame coherence state, two bits each |
| touchVld | input | NUM_FRAMES | Per-frame access strobes |
| selReq | input | 1 | Request a victim choice |
| victimIdx | output | $clog2(NUM_FRAMES) | Chosen frame index |
| victimVld | output | 1 | Pulse marking a valid choice |
| victimNeedsPlace | output | 1 | Victim holds the owning copy |

## Verification
A corrupted recency counter does not show up until a request arrives while every frame is writable. At that point it appears as the wrong index, one cycle after the request. The bench therefore interleaves touch strobes with all-writable requests throughout the run. A fault in class priority shows up at the next request whose mix of states exposes it. A wrong owned flag shows up in the same cycle as the victim pulse.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY    = 2'd0,
    ST_SHARED   = 2'd1,
    ST_OWNED_RD = 2'd2,
    ST_WRITABLE = 2'd3
  } frameSt_e;

  typedef struct packed {
    logic capture;
    logic touch;
  } ctrlStb_t;
endpackage

// File: rtl/victim_sel_ctrl.sv
module victim_sel_ctrl
  import victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic [NUM_FRAMES-1:0] touchVld,
  input  logic                  selReq,
  output ctrlStb_t              stb,
  output logic [IDX_W-1:0]      touchIdx
);
  always_comb begin
    touchIdx = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (touchVld[i]) touchIdx = IDX_W'(i);
    end
    stb.touch   = |touchVld;
    stb.capture = selReq;
  end
endmodule

// File: rtl/victim_sel_dp.sv
module victim_sel_dp
  import victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES),
  localparam int AGE_W = IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_FRAMES-1:0] frameState,
  input  ctrlStb_t                stb,
  input  logic [IDX_W-1:0]        touchIdx,
  output logic [IDX_W-1:0]        victimIdx,
  output logic                    victimVld,
  output logic                    victimNeedsPlace
);
  logic [AGE_W-1:0] age [NUM_FRAMES];
  logic [AGE_W-1:0] touchedAge;

  logic [IDX_W-1:0] emptyIdx, sharedIdx, ownedIdx, lruIdx, pickIdx;
  logic             emptyHit, sharedHit, ownedHit;
  logic [AGE_W-1:0] lruAge;
  logic             pickPlace;

  assign touchedAge = age[touchIdx];

  // recency counters: touched frame goes to zero, younger frames age by one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FRAMES; i++) age[i] <= AGE_W'(i);
    end else if (stb.touch) begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (IDX_W'(i) == touchIdx)     age[i] <= '0;
        else if (age[i] < touchedAge)  age[i] <= age[i] + 1'b1;
      end
    end
  end

  // per-class scans, lowest index wins in the three upper classes
  always_comb begin
    emptyHit = 1'b0; sharedHit = 1'b0; ownedHit = 1'b0;
    emptyIdx = '0;   sharedIdx = '0;   ownedIdx = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      case (frameSt_e'(frameState[2*i +: 2]))
        ST_EMPTY:    begin emptyHit  = 1'b1; emptyIdx  = IDX_W'(i); end
        ST_SHARED:   begin sharedHit = 1'b1; sharedIdx = IDX_W'(i); end
        ST_OWNED_RD: begin ownedHit  = 1'b1; ownedIdx  = IDX_W'(i); end
        default: ;
      endcase
    end
  end

  // oldest writable frame
  always_comb begin
    lruIdx = '0;
    lruAge = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (frameSt_e'(frameState[2*i +: 2]) == ST_WRITABLE && age[i] >= lruAge) begin
        lruAge = age[i];
        lruIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pickPlace = 1'b1;
    if (emptyHit) begin
      pickIdx = emptyIdx;  pickPlace = 1'b0;
    end else if (sharedHit) begin
      pickIdx = sharedIdx; pickPlace = 1'b0;
    end else if (ownedHit) begin
      pickIdx = ownedIdx;
    end else begin
      pickIdx = lruIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimIdx        <= '0;
      victimVld        <= 1'b0;
      victimNeedsPlace <= 1'b0;
    end else begin
      victimVld        <= stb.capture;
      victimNeedsPlace <= stb.capture & pickPlace;
      if (stb.capture) victimIdx <= pickIdx;
    end
  end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_FRAMES-1:0] frameState,
  input  logic [NUM_FRAMES-1:0]   touchVld,
  input  logic                    selReq,
  output logic [IDX_W-1:0]        victimIdx,
  output logic                    victimVld,
  output logic                    victimNeedsPlace
);
  ctrlStb_t         stb;
  logic [IDX_W-1:0] touchIdx;

  victim_sel_ctrl #(.NUM_FRAMES(NUM_FRAMES)) ctrl_i (
    .touchVld (touchVld),
    .selReq   (selReq),
    .stb      (stb),
    .touchIdx (touchIdx)
  );

  victim_sel_dp #(.NUM_FRAMES(NUM_FRAMES)) dp_i (
    .clk              (clk),
    .rstN             (rstN),
    .frameState       (frameState),
    .stb              (stb),
    .touchIdx         (touchIdx),
    .victimIdx        (victimIdx),
    .victimVld        (victimVld),
    .victimNeedsPlace (victimNeedsPlace)
  );
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2*NUM_FRAMES-1:0] frameState,
  input logic                    selReq,
  input logic [IDX_W-1:0]        victimIdx,
  input logic                    victimVld,
  input logic                    victimNeedsPlace
);
  logic [2*NUM_FRAMES-1:0] prevState;
  logic [1:0]              prevVicSt;
  logic                    prevAnyEmpty, prevAnyShared;

  always_ff @(posedge clk) begin
    if (!rstN) prevState <= '0;
    else       prevState <= frameState;
  end

  always_comb begin
    prevVicSt     = 2'(prevState >> {victimIdx, 1'b0});
    prevAnyEmpty  = 1'b0;
    prevAnyShared = 1'b0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (prevState[2*i +: 2] == 2'd0) prevAnyEmpty  = 1'b1;
      if (prevState[2*i +: 2] == 2'd1) prevAnyShared = 1'b1;
    end
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    selReq |=> victimVld); // R1
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rstN)
    !selReq |=> !victimVld); // R1
  AST_PLACE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    victimNeedsPlace |-> victimVld); // R9
  AST_PLACE_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rstN)
    victimVld |-> (victimNeedsPlace == prevVicSt[1])); // R9
  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (victimVld && prevAnyEmpty) |-> (prevVicSt == 2'd0)); // R3
  AST_SHARED_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (victimVld && !prevAnyEmpty && prevAnyShared) |-> (prevVicSt == 2'd1)); // R4
endmodule

bind victim_sel victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) chk_i (.*);

// File: tb/victim_sel_tb_top.sv
module victim_sel_tb_top;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2*N-1:0] frameState = '0;
  logic [N-1:0]  touchVld = '0;
  logic          selReq = 1'b0;
  logic [IW-1:0] victimIdx;
  logic          victimVld;
  logic          victimNeedsPlace;

  int checks = 0;
  int errors = 0;
  int ageM [N];
  logic          pendVld = 1'b0;
  logic [IW-1:0] pendIdx = '0;
  logic          pendPlace = 1'b0;
  logic [1:0]    pendSt = '0;

  always #10 clk = ~clk;

  victim_sel #(.NUM_FRAMES(N)) dut_i (.*);

  function automatic int pickModel(logic [2*N-1:0] st);
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < N; i++)
        if (int'(st[2*i +: 2]) == c) return i;
    begin
      int best = 0;
      for (int i = 0; i < N; i++) if (ageM[i] > ageM[best]) best = i;
      return best;
    end
  endfunction

  function automatic string tagOf(logic [1:0] s);
    case (s)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge: check last cycle's outcome, drive new inputs, advance
  task automatic step(logic [2*N-1:0] st, logic [N-1:0] tch, logic req);
    chk(victimVld == pendVld, "R1", int'(victimVld), int'(pendVld));
    if (pendVld) begin
      chk(victimIdx == pendIdx, tagOf(pendSt), int'(victimIdx), int'(pendIdx));
      chk(victimNeedsPlace == pendPlace, "R9", int'(victimNeedsPlace), int'(pendPlace));
    end else begin
      chk(victimNeedsPlace == 1'b0, "R9", int'(victimNeedsPlace), 0);
    end
    frameState = st; touchVld = tch; selReq = req;
    pendVld = req;
    if (req) begin
      int p = pickModel(st);
      pendIdx = IW'(p);
      pendSt = st[2*p +: 2];
      pendPlace = pendSt[1];
    end
    // R8: lowest touched frame only; R10: model updated after the pick
    for (int i = 0; i < N; i++) begin
      if (tch[i]) begin
        for (int j = 0; j < N; j++) if (j != i && ageM[j] < ageM[i]) ageM[j]++;
        ageM[i] = 0;
        break;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [2*N-1:0] allWr();
    return '1;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) ageM[i] = i;
    repeat (3) @(negedge clk);
    chk(victimVld == 1'b0, "R1", int'(victimVld), 0);
    chk(victimNeedsPlace == 1'b0, "R9", int'(victimNeedsPlace), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset order, frame N-1 least recent
    step(allWr(), '0, 1'b1);
    // R7: touching frame N-1 makes N-2 the oldest
    step(allWr(), N'(1) << (N - 1), 1'b0);
    step(allWr(), '0, 1'b1);
    // R8: several touches, only lowest applies (frame 1 then frame 6 oldest)
    step(allWr(), N'(8'b0100_0010), 1'b0);
    step(allWr(), '0, 1'b1);
    // R10: touch of oldest frame in request cycle does not change this pick
    step(allWr(), N'(1) << 6, 1'b1);
    step(allWr(), '0, 1'b1);
    // R3/R4/R5 directed mixes, R2 encoding
    step({2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd0, 2'd1, 2'd3}, '0, 1'b1);
    step({2'd3, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd2, 2'd1}, '0, 1'b1);
    step({2'd2, 2'd3, 2'd3, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3}, '0, 1'b1);
    step({2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2}, '0, 1'b1);
    step('0, '0, 1'b0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2*N-1:0] st;
      logic [N-1:0] tch;
      int mode = $urandom_range(0, 3);
      for (int i = 0; i < N; i++) begin
        case (mode)
          0: st[2*i +: 2] = 2'($urandom_range(0, 3));
          1: st[2*i +: 2] = ($urandom_range(0, 7) == 0) ? 2'd2 : 2'd3;
          default: st[2*i +: 2] = 2'd3;
        endcase
      end
      tch = ($urandom_range(0, 2) == 0) ? '0 : N'(1) << $urandom_range(0, N - 1);
      if ($urandom_range(0, 9) == 0) tch = N'($urandom);
      step(st, tch, $urandom_range(0, 1) == 1);
    end
    step('0, '0, 1'b0);
    step('0, '0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule